// File: doc/BRIEF.md
# Programmable Dual-Tone and Ringer Synthesizer

This block produces digital call-progress, dialling and ringing tones as a stream of signed linear PCM samples for the receive audio path. Two oscillators, one for a high tone and one for a low tone, each take an 8-bit frequency coefficient. Every sample strobe of the 8 kHz audio frame advances each enabled oscillator's phase by its coefficient, so the tone frequency is 7.8125 Hz per coefficient step.

A control word sets which oscillators are enabled, whether the generator as a whole is on, and whether the block runs in ringer mode. Outside ringer mode the two enabled tones are halved and summed into one sample, which gives a dual-tone dialling signal. In ringer mode only one tone is heard at a time. The block alternates between the high and low frequencies after a fixed number of sample strobes, and a rate bit picks a short or a long interval. A host writes the control word and the two coefficients through a simple byte write port.

Top module: `tone_synth`

## Requirements
- R1: While reset is asserted and afterwards until the first sample strobe, `pcm_out` is 0 and `pcm_valid` is 0. All registers reset to 00h.
- R2: A write to address 1Bh loads the low-tone coefficient and a write to 1Ah loads the high-tone coefficient. A write to 18h loads the control word. A write to any other address changes nothing. A write takes effect from the clock edge that accepts it, so a strobe in that same cycle still sees the old values.
- R3: The control word fields are: bit 7 high-tone enable, bit 6 low-tone enable, bit 5 generator enable, bit 4 ringer mode, bit 3 slow ringer rate. Bits 2..0 are unused. A tone sounds only when bit 5 and its own enable bit are both 1. E0h enables both tones, A0h only the high tone and 60h only the low tone. With bit 5 at 0 the output is 0.
- R4: Each enabled tone holds a 10-bit phase that grows by its coefficient, modulo 1024, on every strobe. Its frequency is therefore 7.8125 Hz times the coefficient. For example, coefficient 40h repeats every 16 strobes.
- R5: A tone's contribution is derived from t, the top 8 bits of its phase before the strobe's advance. Let m = round(32767·|sin(2π(t+0.5)/256)|). The contribution is floor(m/2), negated when t ≥ 128.
- R6: The output sample is the sum of the two contributions. Its magnitude never exceeds 32766, even when both tones peak together.
- R7: A tone that is not enabled has its phase held at 0 and contributes 0. When it is enabled again it starts from phase 0.
- R8: On the clock edge that samples a strobe, `pcm_out` takes the new sample and `pcm_valid` pulses high for one cycle. Between strobes `pcm_out` holds its value.
- R9: In ringer mode, with the generator enabled, only one tone is audible. The high tone sounds first. The selection flips after 200 strobes when bit 3 is 0 and after 400 strobes when bit 3 is 1. Leaving ringer mode or disabling the generator resets the interval count and selects the high tone again.
- R10: In ringer mode the muted tone keeps advancing its phase, so after a switch it resumes from wherever its phase has run to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| sample_tick | input | 1 | One-cycle strobe at the 8 kHz sample rate |
| pcm_out | output | 16 | Signed linear PCM sample |
| pcm_valid | output | 1 | Pulses high for one cycle when a new sample is presented |

## Verification
The checker watches several rules on every cycle. It confirms that each valid pulse follows a strobe and that the sample holds between strobes. It confirms that a disabled oscillator's phase stays cleared and that an enabled oscillator's phase moves by exactly its coefficient. It also confirms that ringer mode never lets both tones through at once, that an interval wrap flips the selected tone, that the sum never reaches the signed limits, and that a fully disabled generator emits zero. Other behaviours can only be shown by the bench's scenarios. These are the exact sine values, the 16-strobe period of coefficient 40h, the 200 and 400 strobe switching points, the restart from phase 0 on re-enable, and the muted ringer tone's continued phase.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;

  // Control word layout, most significant field first (bits 7..3).
  typedef struct packed {
    logic hi_en;
    logic lo_en;
    logic gen_en;
    logic ring_mode;
    logic ring_slow;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Magnitude of one quarter-wave entry, rounded to nearest.
  // Entries sit at half-step offsets so the wave has no zero sample.
  function automatic int quarter_mag(input int idx, input int steps, input int amp);
    real ang;
    ang = 3.14159265358979 / 2.0 * (real'(idx) + 0.5) / real'(steps);
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/tsyn_regs.sv
module tsyn_regs
  import tsyn_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h18,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 6'h1A,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 6'h1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] coef_hi,
  output logic [DATA_W-1:0] coef_lo
);

  logic unused_low_bits;
  assign unused_low_bits = ^wr_data[DATA_W-CTRL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      coef_hi <= '0;
      coef_lo <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_ADDR) ctrl    <= ctrl_t'(wr_data[DATA_W-1 -: CTRL_W]);
      if (wr_addr == HI_ADDR)   coef_hi <= wr_data;
      if (wr_addr == LO_ADDR)   coef_lo <= wr_data;
    end
  end

endmodule

// File: rtl/tsyn_phase_osc.sv
module tsyn_phase_osc
  import tsyn_pkg::*;
#(
  parameter int COEF_W  = 8,
  parameter int PHASE_W = 10,
  parameter int LUT_AW  = 8,
  parameter int AMP_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [COEF_W-1:0]  coef,
  output logic [PHASE_W-1:0] phase,
  output logic [AMP_W-2:0]   mag,
  output logic               neg
);

  localparam int QW      = LUT_AW - 2;
  localparam int QN      = 1 << QW;
  localparam int MAG_W   = AMP_W - 1;
  localparam int AMP_MAX = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] qtab [QN];

  for (genvar i = 0; i < QN; i++) begin : g_qtab
    localparam int ENTRY = quarter_mag(i, QN, AMP_MAX);
    assign qtab[i] = MAG_W'(ENTRY);
  end

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (!run)  phase_q <= '0;
    else if (tick)  phase_q <= phase_q + PHASE_W'(coef);
  end

  logic [LUT_AW-1:0] top_bits;
  logic [QW-1:0]     k;
  logic [QW-1:0]     idx;

  assign top_bits = phase_q[PHASE_W-1 -: LUT_AW];
  assign k        = top_bits[QW-1:0];
  assign idx      = top_bits[QW] ? ~k : k;   // mirror in odd quadrants
  assign mag      = qtab[idx];
  assign neg      = top_bits[LUT_AW-1];      // lower half-wave is negative
  assign phase    = phase_q;

endmodule

// File: rtl/tsyn_ring_sched.sv
module tsyn_ring_sched #(
  parameter int FAST_TICKS = 200,
  parameter int SLOW_TICKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic slow,
  input  logic tick,
  output logic sel_lo,
  output logic wrap
);

  localparam int MAX_T = (FAST_TICKS > SLOW_TICKS) ? FAST_TICKS : SLOW_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             sel_q;

  assign last_cnt = slow ? CNT_W'(SLOW_TICKS - 1) : CNT_W'(FAST_TICKS - 1);
  assign wrap     = active & tick & (cnt_q >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (!active) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (tick) begin
      if (wrap) begin
        cnt_q <= '0;
        sel_q <= ~sel_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sel_lo = sel_q;

endmodule

// File: rtl/tone_synth.sv
module tone_synth
  import tsyn_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int COEF_W     = 8,
  parameter int PHASE_W    = 10,
  parameter int LUT_AW     = 8,
  parameter int PCM_W      = 16,
  parameter int FAST_TICKS = 200,
  parameter int SLOW_TICKS = 400,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h18,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 6'h1A,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 6'h1B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [COEF_W-1:0]       wr_data,
  input  logic                    sample_tick,
  output logic signed [PCM_W-1:0] pcm_out,
  output logic                    pcm_valid
);

  // Halve a magnitude, apply its sign, and gate it by the audible flag.
  function automatic logic signed [PCM_W-1:0] half_contrib(
    input logic [PCM_W-2:0] m, input logic n, input logic on);
    logic signed [PCM_W-1:0] h;
    h = signed'({2'b00, m[PCM_W-2:1]});
    if (!on)   return '0;
    else if (n) return -h;
    else        return h;
  endfunction

  ctrl_t             ctrl;
  logic [COEF_W-1:0] coef_hi;
  logic [COEF_W-1:0] coef_lo;

  tsyn_regs #(
    .ADDR_W(ADDR_W), .DATA_W(COEF_W),
    .CTRL_ADDR(CTRL_ADDR), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .coef_hi(coef_hi), .coef_lo(coef_lo)
  );

  // Named internal events, also observed by the checker.
  logic hi_on, lo_on, ring_act, ring_sel, ring_wrap, hi_aud, lo_aud;

  assign hi_on    = ctrl.gen_en & ctrl.hi_en;
  assign lo_on    = ctrl.gen_en & ctrl.lo_en;
  assign ring_act = ctrl.gen_en & ctrl.ring_mode;

  logic [PHASE_W-1:0] phase_v [2];
  logic [PCM_W-2:0]   mag_v   [2];
  logic               neg_v   [2];
  logic               run_v   [2];
  logic [COEF_W-1:0]  coef_v  [2];

  assign run_v[0]  = hi_on;
  assign run_v[1]  = lo_on;
  assign coef_v[0] = coef_hi;
  assign coef_v[1] = coef_lo;

  for (genvar g = 0; g < 2; g++) begin : g_osc
    tsyn_phase_osc #(
      .COEF_W(COEF_W), .PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .AMP_W(PCM_W)
    ) u_osc (
      .clk(clk), .rst_n(rst_n), .run(run_v[g]), .tick(sample_tick), .coef(coef_v[g]),
      .phase(phase_v[g]), .mag(mag_v[g]), .neg(neg_v[g])
    );
  end

  logic [PHASE_W-1:0] hi_phase, lo_phase;
  assign hi_phase = phase_v[0];
  assign lo_phase = phase_v[1];

  tsyn_ring_sched #(
    .FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)
  ) u_ring (
    .clk(clk), .rst_n(rst_n), .active(ring_act), .slow(ctrl.ring_slow),
    .tick(sample_tick), .sel_lo(ring_sel), .wrap(ring_wrap)
  );

  assign hi_aud = hi_on & (~ring_act | ~ring_sel);
  assign lo_aud = lo_on & (~ring_act |  ring_sel);

  logic signed [PCM_W-1:0] mix;
  assign mix = half_contrib(mag_v[0], neg_v[0], hi_aud)
             + half_contrib(mag_v[1], neg_v[1], lo_aud);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_out   <= '0;
      pcm_valid <= 1'b0;
    end else begin
      pcm_valid <= sample_tick;
      if (sample_tick) pcm_out <= mix;
    end
  end

endmodule

// File: rtl/tone_synth_chk.sv
module tone_synth_chk #(
  parameter int COEF_W  = 8,
  parameter int PHASE_W = 10,
  parameter int PCM_W   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_tick,
  input logic                    hi_on,
  input logic                    lo_on,
  input logic                    ring_act,
  input logic                    ring_sel,
  input logic                    ring_wrap,
  input logic                    hi_aud,
  input logic                    lo_aud,
  input logic [PHASE_W-1:0]      hi_phase,
  input logic [PHASE_W-1:0]      lo_phase,
  input logic [COEF_W-1:0]       coef_hi,
  input logic signed [PCM_W-1:0] pcm_out,
  input logic                    pcm_valid
);

  localparam logic signed [PCM_W-1:0] MOST_NEG = {1'b1, {(PCM_W-1){1'b0}}};
  localparam logic signed [PCM_W-1:0] MOST_POS = {1'b0, {(PCM_W-1){1'b1}}};

  p_valid_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> pcm_valid);

  p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> !pcm_valid);

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |-> $stable(pcm_out));

  p_hi_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_on |=> (hi_phase == '0));

  p_lo_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_on |=> (lo_phase == '0));

  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_on && sample_tick) |=>
      (hi_phase == PHASE_W'($past(hi_phase) + PHASE_W'($past(coef_hi)))));

  p_one_tone_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ring_act |-> !(hi_aud && lo_aud));

  p_wrap_flips_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ring_wrap |=> (ring_sel != $past(ring_sel)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> (pcm_out != MOST_NEG) && (pcm_out != MOST_POS));

  p_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && !$past(hi_on) && !$past(lo_on)) |-> (pcm_out == '0));

endmodule

bind tone_synth tone_synth_chk #(
  .COEF_W(COEF_W), .PHASE_W(PHASE_W), .PCM_W(PCM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
  .hi_on(hi_on), .lo_on(lo_on), .ring_act(ring_act), .ring_sel(ring_sel),
  .ring_wrap(ring_wrap), .hi_aud(hi_aud), .lo_aud(lo_aud),
  .hi_phase(hi_phase), .lo_phase(lo_phase), .coef_hi(coef_hi),
  .pcm_out(pcm_out), .pcm_valid(pcm_valid)
);

// File: tb/tone_synth_tb.sv
`timescale 1ns/1ps
module tone_synth_tb;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [5:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              sample_tick = 1'b0;
  logic signed [15:0] pcm_out;
  logic              pcm_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  tone_synth u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_tick(sample_tick), .pcm_out(pcm_out), .pcm_valid(pcm_valid)
  );

  // Sine value straight from the formula in R5.
  function automatic int tone_val(input int ph);
    int t; real s; int m;
    t = (ph % 1024) / 4;
    s = $sin(2.0 * 3.14159265358979 * (real'(t) + 0.5) / 256.0);
    if (s < 0.0) s = -s;
    m = $rtoi(32767.0 * s + 0.5);
    return (t >= 128) ? -(m / 2) : (m / 2);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ctrl, m_chi, m_clo, m_phh, m_phl, m_cnt, m_sel, m_out, m_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_chi = 0; m_clo = 0; m_phh = 0; m_phl = 0;
      m_cnt = 0; m_sel = 0; m_out = 0; m_val = 0;
    end else begin
      bit gen, hon, lon, ract;
      int per;
      gen  = m_ctrl[5];
      hon  = gen && m_ctrl[7];
      lon  = gen && m_ctrl[6];
      ract = gen && m_ctrl[4];
      m_val = sample_tick;
      if (sample_tick) begin
        m_out = 0;
        if (hon && (!ract || m_sel == 0)) m_out += tone_val(m_phh);
        if (lon && (!ract || m_sel == 1)) m_out += tone_val(m_phl);
      end
      if (!hon) m_phh = 0; else if (sample_tick) m_phh = (m_phh + m_chi) % 1024;
      if (!lon) m_phl = 0; else if (sample_tick) m_phl = (m_phl + m_clo) % 1024;
      if (!ract) begin
        m_cnt = 0; m_sel = 0;
      end else if (sample_tick) begin
        per = m_ctrl[3] ? 400 : 200;
        if (m_cnt >= per - 1) begin m_cnt = 0; m_sel ^= 1; end
        else m_cnt++;
      end
      if (wr_en) begin
        if (wr_addr == 6'h18) m_ctrl = wr_data;
        if (wr_addr == 6'h1A) m_chi  = wr_data;
        if (wr_addr == 6'h1B) m_clo  = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 model sample", int'(pcm_out), m_out);
      chk("R8 model valid", int'(pcm_valid), m_val);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_get(output int v);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    v = int'(pcm_out);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    int saved[32];
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 pcm_out in reset", int'(pcm_out), 0);
    chk("R1 pcm_valid in reset", int'(pcm_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pcm_out after reset", int'(pcm_out), 0);

    // High tone only, coefficient 40h
    wr(6'h1A, 8'h40);
    wr(6'h1B, 8'h10);
    wr(6'h18, 8'hA0);
    for (int n = 0; n < 32; n++) begin
      sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
      v = int'(pcm_out);
      saved[n] = v;
      chk("R5 R3 high-only sample", v, tone_val(64 * n));
      if (n < 2) chk("R8 valid after strobe", int'(pcm_valid), 1);
      @(negedge clk);
      if (n < 2) begin
        chk("R8 valid one cycle", int'(pcm_valid), 0);
        chk("R8 hold between strobes", int'(pcm_out), v);
      end
      if (n >= 16) chk("R4 period 16 strobes", v, saved[n - 16]);
    end

    // Low tone only: high cleared, low starts at phase 0
    wr(6'h18, 8'h60);
    for (int n = 0; n < 8; n++) begin
      tick_get(v);
      chk("R3 R7 low-only sample", v, tone_val(16 * n));
    end
    wr(6'h18, 8'hA0);
    tick_get(v);
    chk("R7 high restarts at phase 0", v, tone_val(0));

    // Dual tone, equal coefficients, peaks coincide
    wr(6'h18, 8'h00);
    wr(6'h1B, 8'h40);
    wr(6'h18, 8'hE0);
    for (int n = 0; n < 16; n++) begin
      tick_get(v);
      chk("R6 dual-tone sum", v, 2 * tone_val(64 * n));
      chk("R6 within range", int'(v > 32766 || v < -32766), 0);
    end
    // R2: writes to other addresses change nothing
    wr(6'h19, 8'hFF);
    wr(6'h1C, 8'h00);
    wr(6'h00, 8'h00);
    wr(6'h3F, 8'h00);
    tick_get(v);
    chk("R2 foreign addresses ignored", v, 2 * tone_val(64 * 16));

    // R3: generator enable clear silences both tones
    wr(6'h18, 8'hC0);
    for (int n = 0; n < 4; n++) begin
      tick_get(v);
      chk("R3 generator off silent", v, 0);
    end

    // Ringer, fast rate
    wr(6'h18, 8'h00);
    wr(6'h1A, 8'h40);
    wr(6'h1B, 8'h20);
    wr(6'h18, 8'hF0);
    for (int n = 0; n < 402; n++) begin
      tick_get(v);
      if ((n / 200) % 2 == 0) chk("R9 fast ringer high", v, tone_val(64 * n));
      else                    chk("R9 R10 fast ringer low", v, tone_val(32 * n));
    end

    // Ringer, slow rate
    wr(6'h18, 8'h00);
    wr(6'h18, 8'hF8);
    for (int n = 0; n < 802; n++) begin
      tick_get(v);
      if ((n / 400) % 2 == 0) chk("R9 slow ringer high", v, tone_val(64 * n));
      else                    chk("R9 R10 slow ringer low", v, tone_val(32 * n));
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule